// File: doc/BRIEF.md
# External Event Counter with Compare

This block is a timer channel that counts qualifying transitions on an asynchronous event input. It raises a one-cycle interrupt pulse each time a programmed number of events has gone by. Software programs three things: a compare value, an edge selection (none, rising, falling or both), and an enable bit together with a three-bit mode field.

The channel runs only while it is enabled and the mode field holds 3'b001. In that state the counter starts parked at FFFFH. The first valid edge only starts the count: it wraps the counter to 0000H and copies the compare register into a shadow buffer. Every later valid edge does one of two things:
- If the count equals the shadow value, it clears the counter to 0000H, pulses the interrupt and reloads the shadow.
- Otherwise it increments the counter.

With compare value D, an interrupt therefore fires once every D+1 valid events. A compare write made while the channel runs only takes effect for the next period. The count and the compare register can be read at any time.

The event input is brought into the clock domain by a two-flop synchronizer, followed by an edge detector. Each level on the event input must be held for at least two clock cycles.

Top module: `evt_counter`

## Requirements
- R1: After reset, count_q reads FFFFH, irq_o is 0 and cmp_q reads 0000H.
- R2: While the channel is inactive (tmr_en is 0, or tmr_mode differs from 3'b001), count_q is held at FFFFH, irq_o stays 0 and event edges are ignored.
- R3: The first valid edge after the channel becomes active sets count_q to 0000H without an interrupt, and captures cmp_q into the shadow buffer.
- R4: On each later valid edge, a count equal to the shadow value clears count_q to 0000H and pulses irq_o high for exactly one cycle; any other count is incremented by one.
- R5: With compare value D, the first interrupt comes on valid edge D+2 after activation, and then one arrives every D+1 valid edges. With D=0, every valid edge after the first one interrupts.
- R6: edge_sel encodes which transitions of evt_in are valid: 2'b00 none, 2'b01 low-to-high, 2'b10 high-to-low, 2'b11 both.
- R7: A compare write while running leaves the current period unchanged. The shadow is reloaded from the compare register only at a match-and-clear, so the new value governs the following period.
- R8: A change on evt_in updates count_q and irq_o at the third rising clock edge after it, provided evt_in holds each level for at least two clocks.
- R9: When cmp_we is high at a clock edge, cmp_q shows cmp_wdata from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_en | input | 1 | Channel enable |
| tmr_mode | input | 3 | Mode field; 3'b001 selects event counting |
| edge_sel | input | 2 | Valid-edge selection |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 16 | Compare register write data |
| evt_in | input | 1 | Asynchronous external event input |
| cmp_q | output | 16 | Compare register read value |
| count_q | output | 16 | Current count read value |
| irq_o | output | 1 | One-cycle compare-match interrupt pulse |

## Verification
An event transition driven on a falling clock edge passes two synchronizer flops and one edge-detect flop, so its effect on count_q and irq_o is due right after the third rising edge. The driver task waits exactly that many edges before it posts the expected count and interrupt to the scoreboard. It posts a second item one cycle later to confirm that the interrupt has fallen again. Compare writes are due one edge after the strobe, and configuration changes are given two edges before count_q is compared. The monitor samples one nanosecond after a rising edge, so no comparison depends on the order of processes at an edge.

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CW = 16,
  parameter logic [2:0] EVT_MODE = 3'b001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmr_en,
  input  logic [2:0]    tmr_mode,
  input  logic [1:0]    edge_sel,
  input  logic          cmp_we,
  input  logic [CW-1:0] cmp_wdata,
  input  logic          evt_in,
  output logic [CW-1:0] cmp_q,
  output logic [CW-1:0] count_q,
  output logic          irq_o
);
  localparam logic [CW-1:0] PARK = '1;

  logic          s_meta, s_sync, s_prev;
  logic          armed;
  logic [CW-1:0] shadow;
  logic          active, rise, fall, hit;

  assign active = tmr_en && (tmr_mode == EVT_MODE);
  assign rise   = s_sync && !s_prev;
  assign fall   = !s_sync && s_prev;
  assign hit    = active && ((edge_sel[0] && rise) || (edge_sel[1] && fall));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s_meta, s_sync, s_prev} <= '0;
    else        {s_meta, s_sync, s_prev} <= {evt_in, s_meta, s_sync};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_we) cmp_q <= cmp_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= PARK;
      shadow  <= '0;
      armed   <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (!active) begin
        count_q <= PARK;
        armed   <= 1'b0;
      end else if (hit) begin
        if (!armed || count_q == shadow) begin
          count_q <= '0;
          shadow  <= cmp_q;
          armed   <= 1'b1;
          irq_o   <= armed;
        end else begin
          count_q <= count_q + 1'b1;
        end
      end
    end
  end
endmodule

module evt_counter_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tmr_en,
  input logic [2:0]    tmr_mode,
  input logic          cmp_we,
  input logic [CW-1:0] cmp_wdata,
  input logic [CW-1:0] cmp_q,
  input logic [CW-1:0] count_q,
  input logic          irq_o
);
  logic run;
  assign run = tmr_en && (tmr_mode == 3'b001);

  a_r2_parked_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count_q == {CW{1'b1}});

  a_r2_no_irq_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !irq_o);

  a_r4_irq_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  a_r4_irq_with_clear: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> count_q == '0);

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(count_q)) |->
      (count_q == '0 || count_q == $past(count_q) + 1'b1));

  a_r9_cmp_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> cmp_q == $past(cmp_wdata));
endmodule

bind evt_counter evt_counter_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .tmr_mode(tmr_mode),
  .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .cmp_q(cmp_q),
  .count_q(count_q), .irq_o(irq_o)
);

// File: tb/test_evt_counter.sv
`timescale 1ns/1ps
module test_evt_counter;
  logic        clk = 0, rst_n = 0;
  logic        tmr_en = 0, cmp_we = 0, evt_in = 0;
  logic [2:0]  tmr_mode = 0;
  logic [1:0]  edge_sel = 0;
  logic [15:0] cmp_wdata = 0;
  logic [15:0] cmp_q, count_q;
  logic        irq_o;

  evt_counter i_evt_counter (.*);

  always #2.5 clk = ~clk;

  typedef struct { logic [15:0] cnt; logic irq; string tag; } item_t;
  item_t q[$];
  event  item_ev;
  int    total = 0, bad = 0;

  logic        m_act = 0, m_arm = 0, m_lvl = 0, m_irq = 0;
  logic [15:0] m_cnt = 16'hFFFF, m_buf = 0, m_cmp = 0;

  task automatic push(string tag);
    item_t it;
    it.cnt = m_cnt; it.irq = m_irq; it.tag = tag;
    q.push_back(it);
    -> item_ev;
  endtask

  always begin
    @(item_ev);
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (count_q !== it.cnt || irq_o !== it.irq) begin
        bad++;
        $display("FAIL %s: count=%h irq=%b expected count=%h irq=%b",
                 it.tag, count_q, irq_o, it.cnt, it.irq);
      end
    end
  end

  task automatic cfg(logic en, logic [2:0] md, logic [1:0] sel, string tag);
    @(negedge clk);
    tmr_en = en; tmr_mode = md; edge_sel = sel;
    m_act = en && md == 3'b001;
    if (!m_act) begin m_cnt = 16'hFFFF; m_arm = 0; end
    m_irq = 0;
    repeat (2) @(posedge clk);
    #1 push(tag);
  endtask

  task automatic wr_cmp(logic [15:0] v);
    @(negedge clk);
    cmp_we = 1; cmp_wdata = v;
    @(negedge clk);
    cmp_we = 0;
    m_cmp = v;
    total++;
    if (cmp_q !== v) begin
      bad++;
      $display("FAIL R9: cmp_q=%h expected %h", cmp_q, v);
    end
  endtask

  task automatic ev(logic lvl, string tag);
    logic hit;
    @(negedge clk);
    evt_in = lvl;
    hit = m_act && lvl != m_lvl &&
          ((edge_sel[0] && lvl) || (edge_sel[1] && !lvl));
    m_lvl = lvl;
    m_irq = 0;
    if (hit) begin
      if (!m_arm) begin m_cnt = 0; m_buf = m_cmp; m_arm = 1; end
      else if (m_cnt == m_buf) begin m_cnt = 0; m_buf = m_cmp; m_irq = 1; end
      else m_cnt = m_cnt + 1;
    end
    repeat (3) @(posedge clk);
    #1 push(tag);
    m_irq = 0;
    @(posedge clk);
    #1 push({tag, " irq drop"});
  endtask

  task automatic pulses(int n, string tag);
    for (int i = 0; i < n; i++) begin
      ev(1, tag);
      ev(0, tag);
    end
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (count_q !== 16'hFFFF || irq_o !== 0 || cmp_q !== 0) begin
      bad++;
      $display("FAIL R1: count=%h irq=%b cmp=%h expected FFFF 0 0000", count_q, irq_o, cmp_q);
    end
    @(negedge clk) rst_n = 1;

    wr_cmp(16'd3);
    cfg(0, 3'b001, 2'b01, "R2 disabled");
    pulses(3, "R2 disabled edges ignored");
    cfg(1, 3'b010, 2'b01, "R2 wrong mode");
    pulses(3, "R2 wrong mode edges ignored");

    cfg(1, 3'b001, 2'b01, "R3 parked at start");
    pulses(1, "R3 first edge");
    pulses(9, "R4 R5 R8 rising D=3");

    cfg(1, 3'b001, 2'b10, "R6 falling select");
    pulses(5, "R6 falling only");
    cfg(1, 3'b001, 2'b11, "R6 both select");
    pulses(5, "R6 both edges");
    cfg(1, 3'b001, 2'b00, "R6 none select");
    pulses(3, "R6 none counts nothing");

    cfg(1, 3'b001, 2'b01, "R7 reselect rising");
    wr_cmp(16'd1);
    pulses(10, "R7 new compare next period");

    wr_cmp(16'd0);
    cfg(0, 3'b001, 2'b01, "R2 disable parks");
    cfg(1, 3'b001, 2'b01, "R5 restart");
    pulses(6, "R5 D=0 every edge");

    cfg(0, 3'b001, 2'b01, "R2 final disable");
    pulses(2, "R2 final ignored");

    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule